// File: doc/BRIEF.md
# Unaligned Access Bridge for Unit-Wide Memory

This block sits between a load/store requester and a memory that can only read or write whole 8-byte units. It has no byte enables. The requester hands over one request at a time: a byte address, a size code, a read/write flag and store data. The bridge turns that request into whole-unit memory commands and answers with a single response.

A load whose bytes stay inside one unit takes one read. A load whose bytes run past the end of a unit reads unit N and then unit N+1. The two units are shifted by the byte offset and joined. Every store is done as read, merge, write. A store that runs past the end of a unit reads both units, merges the object's bytes into each, and then writes both back.

An access is aligned when its address is a multiple of its size. A strict-mode pin makes the bridge reject misaligned requests with a fault. When the pin is low, misaligned requests are carried out with the multi-transfer sequences.

The request side is a valid/ready stream. A request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` then stays low until the response cycle is over, so back-pressure lasts for the whole sequence. The response is a one-cycle `resp_valid` pulse with no ready: the requester must always accept it.

The memory command side is also valid/ready. While `mem_ready` is low the bridge holds its command steady. Read data comes back on a `mem_rdata_valid` pulse at least one cycle after the read command is accepted, with any latency. Each step waits for the read data it depends on.

Top module: `split_access_bridge`

## Requirements
- R1: After reset `req_ready` is high, and `mem_valid` and `resp_valid` are low. No memory command is raised while `req_ready` is high.
- R2: `req_size` codes 0, 1, 2 and 3 select 1, 2, 4 and 8 bytes. Bytes are little-endian. A load whose bytes lie in one unit issues exactly one read, of unit index address/8. It returns those bytes zero-extended to 64 bits.
- R3: A load that runs past the end of unit N issues exactly two reads, of unit N and then unit N+1. Its lowest bytes come from the top of unit N and the rest from the bottom of unit N+1.
- R4: A store whose bytes lie in one unit issues exactly two commands: a read of that unit, then a write of it. The written unit changes only the addressed bytes. Store data above the access size is ignored.
- R5: A store that runs past the end of unit N issues exactly four commands, in this order: read N, read N+1, write N, write N+1. Bytes outside the object keep their values in both units.
- R6: With `strict_en` high, a misaligned request issues no memory command and changes no memory. It responds with `resp_fault` high and `resp_rdata` zero.
- R7: An aligned request never faults in either mode. With `strict_en` low, a misaligned request is performed normally.
- R8: Once a request is accepted, `req_ready` stays low until the response. `resp_valid` lasts exactly one cycle and is followed by `req_ready` high. A store responds with zero data and no fault.
- R9: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_write`, `mem_idx` and `mem_wdata` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strict_en | input | 1 | Fault on misaligned requests when high |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Bridge idle and able to take a request |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | Size code: 0=1, 1=2, 2=4, 3=8 bytes |
| req_write | input | 1 | 1 for a store, 0 for a load |
| req_wdata | input | DATA_W | Store data, least significant byte first |
| resp_valid | output | 1 | One-cycle response pulse |
| resp_rdata | output | DATA_W | Zero-extended load data (zero for stores and faults) |
| resp_fault | output | 1 | Misalignment fault, valid with resp_valid |
| mem_valid | output | 1 | Memory command valid |
| mem_ready | input | 1 | Memory command accepted |
| mem_write | output | 1 | 1 for a unit write, 0 for a unit read |
| mem_idx | output | ADDR_W-3 | Unit index |
| mem_wdata | output | DATA_W | Whole unit to be written |
| mem_rdata | input | DATA_W | Returned unit data |
| mem_rdata_valid | input | 1 | Returned data valid pulse |

## Verification
The bench builds the bridge with a 10-bit address, which gives a 7-bit unit index, and the default 64-bit unit width. That is enough to place objects across every kind of unit boundary inside a small modelled memory of 16 units.

The memory model runs in two settings. The first has immediate acceptance and return. The second has three stall cycles on every command and four cycles of read latency. The second setting exercises the hold-steady rule and the wait for dependent read data.

`strict_en` is driven both high and low. This shows that the same misaligned address faults in one mode and completes in the other, and that aligned traffic is never affected.

// File: rtl/sab_pkg.sv
`timescale 1ns/1ps
package sab_pkg;
  localparam int SAB_DATA_W = 64;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD0,
    ST_WAIT0,
    ST_RD1,
    ST_WAIT1,
    ST_WR0,
    ST_WR1,
    ST_RESP
  } sab_state_e;
endpackage

// File: rtl/sab_decode.sv
`timescale 1ns/1ps
module sab_decode #(
  parameter int ADDR_W     = 32,
  parameter int UNIT_BYTES = 8,
  parameter int OFF_W      = $clog2(UNIT_BYTES)
) (
  input  logic [ADDR_W-1:0]     addr,
  input  logic [1:0]            size,
  output logic [OFF_W-1:0]      off,
  output logic [UNIT_BYTES-1:0] bmask,
  output logic                  misaligned,
  output logic                  crosses
);
  logic [OFF_W:0]   nbytes;
  logic [OFF_W-1:0] lowmask;

  always_comb begin
    off        = addr[OFF_W-1:0];
    nbytes     = (OFF_W+1)'(1) << size;
    lowmask    = OFF_W'(nbytes - (OFF_W+1)'(1));
    misaligned = |(off & lowmask);
    crosses    = ({1'b0, off} + nbytes) > (OFF_W+1)'(UNIT_BYTES);
  end

  generate
    for (genvar i = 0; i < UNIT_BYTES; i++) begin : g_mask
      assign bmask[i] = (OFF_W+1)'(i) < nbytes;
    end
  endgenerate
endmodule

// File: rtl/sab_load_align.sv
`timescale 1ns/1ps
module sab_load_align #(
  parameter int DATA_W     = 64,
  parameter int UNIT_BYTES = DATA_W / 8,
  parameter int OFF_W      = $clog2(UNIT_BYTES)
) (
  input  logic [DATA_W-1:0]     lo_unit,
  input  logic [DATA_W-1:0]     hi_unit,
  input  logic [OFF_W-1:0]      off,
  input  logic [UNIT_BYTES-1:0] bmask,
  output logic [DATA_W-1:0]     data
);
  logic [DATA_W-1:0] shifted;

  // Pair of units seen as one little-endian window, moved down by the offset
  assign shifted = DATA_W'({hi_unit, lo_unit} >> {off, 3'b000});

  generate
    for (genvar i = 0; i < UNIT_BYTES; i++) begin : g_byte
      assign data[8*i +: 8] = bmask[i] ? shifted[8*i +: 8] : 8'h00;
    end
  endgenerate
endmodule

// File: rtl/sab_store_merge.sv
`timescale 1ns/1ps
module sab_store_merge #(
  parameter int DATA_W     = 64,
  parameter int UNIT_BYTES = DATA_W / 8,
  parameter int OFF_W      = $clog2(UNIT_BYTES)
) (
  input  logic [DATA_W-1:0]     old_lo,
  input  logic [DATA_W-1:0]     old_hi,
  input  logic [DATA_W-1:0]     wdata,
  input  logic [OFF_W-1:0]      off,
  input  logic [UNIT_BYTES-1:0] bmask,
  output logic [DATA_W-1:0]     new_lo,
  output logic [DATA_W-1:0]     new_hi
);
  logic [2*DATA_W-1:0]     old_w;
  logic [2*DATA_W-1:0]     dat_w;
  logic [2*DATA_W-1:0]     new_w;
  logic [2*UNIT_BYTES-1:0] msk_w;

  assign old_w = {old_hi, old_lo};
  assign dat_w = {DATA_W'(0), wdata} << {off, 3'b000};
  assign msk_w = {UNIT_BYTES'(0), bmask} << off;

  generate
    for (genvar i = 0; i < 2*UNIT_BYTES; i++) begin : g_byte
      assign new_w[8*i +: 8] = msk_w[i] ? dat_w[8*i +: 8] : old_w[8*i +: 8];
    end
  endgenerate

  assign new_lo = new_w[DATA_W-1:0];
  assign new_hi = new_w[2*DATA_W-1:DATA_W];
endmodule

// File: rtl/split_access_bridge.sv
`timescale 1ns/1ps
module split_access_bridge
  import sab_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = SAB_DATA_W
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   strict_en,
  input  logic                                   req_valid,
  output logic                                   req_ready,
  input  logic [ADDR_W-1:0]                      req_addr,
  input  logic [1:0]                             req_size,
  input  logic                                   req_write,
  input  logic [DATA_W-1:0]                      req_wdata,
  output logic                                   resp_valid,
  output logic [DATA_W-1:0]                      resp_rdata,
  output logic                                   resp_fault,
  output logic                                   mem_valid,
  input  logic                                   mem_ready,
  output logic                                   mem_write,
  output logic [ADDR_W-$clog2(DATA_W/8)-1:0]     mem_idx,
  output logic [DATA_W-1:0]                      mem_wdata,
  input  logic [DATA_W-1:0]                      mem_rdata,
  input  logic                                   mem_rdata_valid
);
  localparam int UB    = DATA_W / 8;
  localparam int OFF_W = $clog2(UB);
  localparam int IDX_W = ADDR_W - OFF_W;

  sab_state_e        st;
  logic [ADDR_W-1:0] addr_q;
  logic [1:0]        size_q;
  logic              write_q;
  logic              fault_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] buf0;
  logic [DATA_W-1:0] buf1;

  logic [ADDR_W-1:0] dec_addr;
  logic [1:0]        dec_size;
  logic [OFF_W-1:0]  off;
  logic [UB-1:0]     bmask;
  logic              misaligned;
  logic              crosses;
  logic [DATA_W-1:0] load_data;
  logic [DATA_W-1:0] new_lo;
  logic [DATA_W-1:0] new_hi;
  logic [IDX_W-1:0]  idx_q;

  // Live request is decoded while idle, the held one afterwards
  assign dec_addr = (st == ST_IDLE) ? req_addr : addr_q;
  assign dec_size = (st == ST_IDLE) ? req_size : size_q;
  assign idx_q    = addr_q[ADDR_W-1:OFF_W];

  sab_decode #(.ADDR_W(ADDR_W), .UNIT_BYTES(UB), .OFF_W(OFF_W)) u_dec (
    .addr       (dec_addr),
    .size       (dec_size),
    .off        (off),
    .bmask      (bmask),
    .misaligned (misaligned),
    .crosses    (crosses)
  );

  sab_load_align #(.DATA_W(DATA_W), .UNIT_BYTES(UB), .OFF_W(OFF_W)) u_load (
    .lo_unit (buf0),
    .hi_unit (buf1),
    .off     (off),
    .bmask   (bmask),
    .data    (load_data)
  );

  sab_store_merge #(.DATA_W(DATA_W), .UNIT_BYTES(UB), .OFF_W(OFF_W)) u_merge (
    .old_lo (buf0),
    .old_hi (buf1),
    .wdata  (wdata_q),
    .off    (off),
    .bmask  (bmask),
    .new_lo (new_lo),
    .new_hi (new_hi)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      addr_q  <= '0;
      size_q  <= '0;
      write_q <= 1'b0;
      fault_q <= 1'b0;
      wdata_q <= '0;
      buf0    <= '0;
      buf1    <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (req_valid) begin
          addr_q  <= req_addr;
          size_q  <= req_size;
          write_q <= req_write;
          wdata_q <= req_wdata;
          if (strict_en && misaligned) begin
            fault_q <= 1'b1;
            st      <= ST_RESP;
          end else begin
            fault_q <= 1'b0;
            st      <= ST_RD0;
          end
        end
        ST_RD0: if (mem_ready) st <= ST_WAIT0;
        ST_WAIT0: if (mem_rdata_valid) begin
          buf0 <= mem_rdata;
          if (crosses)      st <= ST_RD1;
          else if (write_q) st <= ST_WR0;
          else              st <= ST_RESP;
        end
        ST_RD1: if (mem_ready) st <= ST_WAIT1;
        ST_WAIT1: if (mem_rdata_valid) begin
          buf1 <= mem_rdata;
          st   <= write_q ? ST_WR0 : ST_RESP;
        end
        ST_WR0: if (mem_ready) st <= crosses ? ST_WR1 : ST_RESP;
        ST_WR1: if (mem_ready) st <= ST_RESP;
        ST_RESP: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    req_ready  = (st == ST_IDLE);
    mem_valid  = (st == ST_RD0) || (st == ST_RD1) || (st == ST_WR0) || (st == ST_WR1);
    mem_write  = (st == ST_WR0) || (st == ST_WR1);
    mem_idx    = ((st == ST_RD1) || (st == ST_WR1)) ? idx_q + IDX_W'(1) : idx_q;
    mem_wdata  = (st == ST_WR1) ? new_hi : ((st == ST_WR0) ? new_lo : '0);
    resp_valid = (st == ST_RESP);
    resp_fault = (st == ST_RESP) && fault_q;
    resp_rdata = ((st == ST_RESP) && !write_q && !fault_q) ? load_data : '0;
  end
endmodule

// File: rtl/sab_checker.sv
`timescale 1ns/1ps
module sab_checker #(
  parameter int IDX_W  = 29,
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              resp_valid,
  input logic              resp_fault,
  input logic [DATA_W-1:0] resp_rdata,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic              mem_write,
  input logic [IDX_W-1:0]  mem_idx,
  input logic [DATA_W-1:0] mem_wdata
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!mem_valid && !resp_valid));

  // R8
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R8
  resp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> (!resp_valid && req_ready));

  // R6
  fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_fault |-> (resp_valid && resp_rdata == '0));

  // R9
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=>
      (mem_valid && $stable(mem_idx) && $stable(mem_write) && $stable(mem_wdata)));
endmodule

bind split_access_bridge sab_checker #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_sab_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .resp_valid (resp_valid),
  .resp_fault (resp_fault),
  .resp_rdata (resp_rdata),
  .mem_valid  (mem_valid),
  .mem_ready  (mem_ready),
  .mem_write  (mem_write),
  .mem_idx    (mem_idx),
  .mem_wdata  (mem_wdata)
);

// File: tb/tb_split_access_bridge.sv
`timescale 1ns/1ps
module tb_split_access_bridge;
  localparam int AW = 10;
  localparam int DW = 64;
  localparam int UW = AW - 3;

  logic          clk, rst_n, strict_en;
  logic          req_valid, req_ready, req_write;
  logic [AW-1:0] req_addr;
  logic [1:0]    req_size;
  logic [DW-1:0] req_wdata, resp_rdata, mem_wdata, mem_rdata;
  logic          resp_valid, resp_fault;
  logic          mem_valid, mem_ready, mem_write, mem_rdata_valid;
  logic [UW-1:0] mem_idx;

  split_access_bridge #(.ADDR_W(AW), .DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .strict_en(strict_en),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
    .resp_valid(resp_valid), .resp_rdata(resp_rdata), .resp_fault(resp_fault),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
    .mem_idx(mem_idx), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_rdata_valid(mem_rdata_valid)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;

  logic [63:0] mem   [16];
  logic [63:0] ref_m [16];
  int stall_cfg = 0;
  int lat_cfg   = 0;
  int stall_cnt, lat_cnt;
  bit rd_pend, hs_pend, was_stalled, hold_bad;
  logic [63:0]   rd_data, h_wd, s_wd;
  logic          h_wr, s_wr;
  logic [UW-1:0] h_idx, s_idx;
  int            xfer_n;
  logic          xfer_wr  [8];
  logic [UW-1:0] xfer_idx [8];

  // Memory model: reacts on falling edges, the bridge samples on rising edges
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ready = 0; mem_rdata_valid = 0; mem_rdata = '0;
      hs_pend = 0; rd_pend = 0; stall_cnt = 0; was_stalled = 0;
    end else begin
      mem_rdata_valid = 0;
      if (hs_pend) begin
        hs_pend = 0;
        if (xfer_n < 8) begin xfer_wr[xfer_n] = h_wr; xfer_idx[xfer_n] = h_idx; end
        xfer_n++;
        if (h_wr) mem[h_idx[3:0]] = h_wd;
        else begin rd_pend = 1; lat_cnt = lat_cfg; rd_data = mem[h_idx[3:0]]; end
      end else if (rd_pend) begin
        if (lat_cnt == 0) begin
          mem_rdata_valid = 1; mem_rdata = rd_data; rd_pend = 0;
        end else lat_cnt--;
      end
      if (rd_pend && lat_cfg == 0 && lat_cnt == 0 && !mem_rdata_valid) begin
        mem_rdata_valid = 1; mem_rdata = rd_data; rd_pend = 0;
      end
      if (was_stalled && (!mem_valid || mem_idx != s_idx || mem_write != s_wr || mem_wdata != s_wd))
        hold_bad = 1;
      mem_ready = 0; was_stalled = 0;
      if (mem_valid) begin
        if (stall_cnt < stall_cfg) begin
          stall_cnt++; was_stalled = 1;
          s_idx = mem_idx; s_wr = mem_write; s_wd = mem_wdata;
        end else begin
          mem_ready = 1; hs_pend = 1; stall_cnt = 0;
          h_wr = mem_write; h_idx = mem_idx; h_wd = mem_wdata;
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] mbyte(input int a);
    return mem[(a >> 3) & 15][(a & 7)*8 +: 8];
  endfunction

  function automatic logic [63:0] exp_load(input int a, input int sz);
    logic [63:0] r = '0;
    for (int i = 0; i < (1 << sz); i++) r[8*i +: 8] = mbyte(a + i);
    return r;
  endfunction

  task automatic run_req(input int a, input int sz, input bit wr, input logic [63:0] wd,
                         output logic [63:0] rdata, output logic fault);
    bit ready_bad = 0;
    int n = 0;
    @(negedge clk);
    xfer_n = 0;
    req_valid = 1; req_addr = AW'(a); req_size = 2'(sz); req_write = wr; req_wdata = wd;
    @(negedge clk);
    req_valid = 0;
    while (!resp_valid && n < 500) begin
      if (req_ready) ready_bad = 1;
      @(negedge clk); n++;
    end
    if (req_ready) ready_bad = 1;
    rdata = resp_rdata; fault = resp_fault;
    chk("R8 ready low while busy", 64'(ready_bad), 64'd0);
    @(negedge clk);
    chk("R8 single response pulse, ready again", {62'd0, resp_valid, req_ready}, 64'd1);
  endtask

  task automatic snap_ref();
    for (int u = 0; u < 16; u++) ref_m[u] = mem[u];
  endtask

  task automatic cmp_mem(input string tag);
    int bad = -1;
    for (int u = 0; u < 16; u++) if (mem[u] !== ref_m[u] && bad < 0) bad = u;
    if (bad < 0) chk(tag, 64'd0, 64'd0);
    else chk(tag, mem[bad], ref_m[bad]);
  endtask

  task automatic t_reset();
    chk("R1 reset outputs", {61'd0, req_ready, mem_valid, resp_valid}, 64'd4);
  endtask

  task automatic t_load(input string tag, input int a, input int sz);
    logic [63:0] d, e; logic f;
    e = exp_load(a, sz);
    run_req(a, sz, 0, '0, d, f);
    chk({tag, " data"}, d, e);
    chk({tag, " fault"}, 64'(f), 64'd0);
    if (((a & 7) + (1 << sz)) > 8) begin
      chk({tag, " R3 transfer count"}, 64'(xfer_n), 64'd2);
      chk({tag, " R3 order"}, {48'd0, 1'b0, xfer_wr[0], 7'(xfer_idx[0]), 1'b0, xfer_wr[1], 7'(xfer_idx[1])},
          {48'd0, 1'b0, 1'b0, 7'(a >> 3), 1'b0, 1'b0, 7'((a >> 3) + 1)});
    end else begin
      chk({tag, " R2 transfer count"}, 64'(xfer_n), 64'd1);
      chk({tag, " R2 read index"}, {56'd0, xfer_wr[0], 7'(xfer_idx[0])}, {56'd0, 1'b0, 7'(a >> 3)});
    end
  endtask

  task automatic t_store(input string tag, input int a, input int sz, input logic [63:0] wd);
    logic [63:0] d; logic f; int n;
    snap_ref();
    for (int i = 0; i < (1 << sz); i++)
      ref_m[((a + i) >> 3) & 15][((a + i) & 7)*8 +: 8] = wd[8*i +: 8];
    run_req(a, sz, 1, wd, d, f);
    chk({tag, " R8 store response"}, {d[62:0], f}, 64'd0);
    cmp_mem({tag, " memory contents"});
    if (((a & 7) + (1 << sz)) > 8) begin
      n = 4;
      chk({tag, " R5 order"},
          {32'd0, xfer_wr[0], 7'(xfer_idx[0]), xfer_wr[1], 7'(xfer_idx[1]),
                  xfer_wr[2], 7'(xfer_idx[2]), xfer_wr[3], 7'(xfer_idx[3])},
          {32'd0, 1'b0, 7'(a >> 3), 1'b0, 7'((a >> 3) + 1), 1'b1, 7'(a >> 3), 1'b1, 7'((a >> 3) + 1)});
    end else begin
      n = 2;
      chk({tag, " R4 order"}, {48'd0, xfer_wr[0], 7'(xfer_idx[0]), xfer_wr[1], 7'(xfer_idx[1])},
          {48'd0, 1'b0, 7'(a >> 3), 1'b1, 7'(a >> 3)});
    end
    chk({tag, " transfer count"}, 64'(xfer_n), 64'(n));
  endtask

  task automatic t_aligned_loads();
    t_load("R2 byte", 16'h15, 0);
    t_load("R2 half", 16'h12, 1);
    t_load("R2 word", 16'h1C, 2);
    t_load("R2 dword", 16'h20, 3);
  endtask

  task automatic t_cross_loads();
    t_load("R3 word 7..10", 16'h07, 2);
    t_load("R3 dword", 16'h13, 3);
    t_load("R3 half", 16'h0F, 1);
  endtask

  task automatic t_single_stores();
    t_store("R4 dword", 16'h28, 3, 64'hA1B2C3D4E5F60718);
    t_store("R4 half misaligned", 16'h21, 1, 64'hFFFFFFFFFFFF9E3C);
    t_store("R4 byte", 16'h36, 0, 64'h123456789ABCDE77);
  endtask

  task automatic t_cross_stores();
    t_store("R5 word", 16'h3E, 2, 64'h00000000CAFEBABE);
    t_store("R5 dword", 16'h45, 3, 64'h0123456789ABCDEF);
  endtask

  task automatic t_strict();
    logic [63:0] d, e; logic f;
    strict_en = 1;
    snap_ref();
    run_req(16'h07, 2, 0, '0, d, f);
    chk("R6 load fault flag", 64'(f), 64'd1);
    chk("R6 load fault data", d, 64'd0);
    chk("R6 load no transfers", 64'(xfer_n), 64'd0);
    run_req(16'h0B, 3, 1, 64'hDEADBEEFDEADBEEF, d, f);
    chk("R6 store fault flag", 64'(f), 64'd1);
    chk("R6 store no transfers", 64'(xfer_n), 64'd0);
    cmp_mem("R6 memory untouched");
    e = exp_load(16'h10, 2);
    run_req(16'h10, 2, 0, '0, d, f);
    chk("R7 strict aligned data", d, e);
    chk("R7 strict aligned fault", 64'(f), 64'd0);
    strict_en = 0;
    e = exp_load(16'h0B, 3);
    run_req(16'h0B, 3, 0, '0, d, f);
    chk("R7 relaxed misaligned data", d, e);
    chk("R7 relaxed misaligned fault", 64'(f), 64'd0);
  endtask

  task automatic t_backpressure();
    stall_cfg = 3; lat_cfg = 4; hold_bad = 0;
    t_store("R9 slow crossing store", 16'h4E, 2, 64'h000000005566AA99);
    t_load("R9 slow crossing load", 16'h4D, 3);
    chk("R9 command held during stall", 64'(hold_bad), 64'd0);
    stall_cfg = 0; lat_cfg = 0;
  endtask

  initial begin
    #4_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hang expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 0; strict_en = 0; req_valid = 0; req_addr = '0; req_size = '0;
    req_write = 0; req_wdata = '0; hold_bad = 0; xfer_n = 0;
    mem_ready = 0; mem_rdata_valid = 0; mem_rdata = '0;
    for (int u = 0; u < 16; u++)
      for (int b = 0; b < 8; b++) mem[u][8*b +: 8] = 8'(u*8 + b) ^ 8'h5A;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_aligned_loads();
    t_cross_loads();
    t_single_stores();
    t_cross_stores();
    t_strict();
    t_backpressure();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule